// File: doc/BRIEF.md
# VFD Multiplex Shutdown and Blink Sequencer

This block sets the multiplex timing for a vacuum-fluorescent display controller. It splits the oscillator clock into digit slots of fixed length and reports the slot being driven. It gives a one-cycle strobe as each slot ends. It also drives the square-wave pump clock, two complementary filament phases and the blink phase used by the cursor and annunciator logic further down the chip.

Shutdown never cuts a slot short. When the run request drops, the slot in progress is finished and only then does the scan stop. While the scan is stopped, the blanking output turns the tube driver off and the pump and filament outputs are held low. When the scan starts again, it begins at slot zero and keeps the display blanked for one whole scan, because the tube driver's contents cannot be trusted at that point. Display test mode counts as a run request whatever the shutdown bit holds. A sync pulse restarts both the scan and the blink timer. This lets several controllers blink in step.

Top module: `vfd_mux_seq`

## Requirements
- R1: Each slot lasts SLOT_CLKS clocks while running. `slot_strobe` is high for exactly the last clock of each slot. `slot_idx` then advances by one, or wraps to 0 after the last slot. There are SLOTS_WIDE slots when `cfg_wide`=1 and SLOTS_NARROW slots when `cfg_wide`=0.
- R2: When neither `cfg_run` nor `test_mode` is high, the current slot runs to its end, with its strobe, and the scan then stops.
- R3: While stopped, `blank`=1, `slot_strobe`=0 and `slot_idx` holds its value.
- R4: While running with `pump_sq_en`=1, `pump_clk` is a square wave of period PUMP_DIV that starts low for PUMP_DIV/2 clocks after a wake. It is 0 when stopped or when `pump_sq_en`=0.
- R5: While running, `fil_phase1` is a square wave of period FIL_DIV that starts low after a wake. `fil_phase2` is its complement. Each output is 0 when its enable is 0 or when the scan is stopped.
- R6: The clock edge that starts a stopped scan resets the slot, slot counter, blink timer and drive counters to zero. `blank` stays 1 until the last slot of the first complete scan has ended, and is 0 from then on.
- R7: `test_mode`=1 runs the scan even when `cfg_run`=0.
- R8: A clock with `cfg_sync`=1 makes the next slot start at slot 0 with a fresh slot count, and clears the blink timer and `blink_phase`. The drive counters are not affected.
- R9: While running, `blink_phase` toggles every 2^BLINK_SHIFT clocks when `cfg_blink_slow`=0, and every 2^(BLINK_SHIFT+1) clocks when it is 1.
- R10: When `cfg_wide` changes to 0 while `slot_idx` is at or above SLOTS_NARROW-1, the current slot finishes and the next one is slot 0.
- R11: After reset the scan is stopped with `slot_idx`=0, `blank`=1, and `pump_clk`, both filament phases, `blink_phase` and `slot_strobe` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | 1 = normal operation, 0 = shutdown |
| cfg_blink_slow | input | 1 | Selects the slower blink rate |
| cfg_sync | input | 1 | Restart scan and blink timing |
| cfg_wide | input | 1 | 1 = wide slot count, 0 = narrow slot count |
| test_mode | input | 1 | Display test, overrides shutdown |
| pump_sq_en | input | 1 | Pump output acts as square-wave clock |
| fil1_en | input | 1 | Phase output 1 acts as filament drive |
| fil2_en | input | 1 | Phase output 2 acts as filament drive |
| slot_idx | output | $clog2(SLOTS_WIDE) | Slot being driven |
| slot_strobe | output | 1 | Last clock of a slot |
| blank | output | 1 | Disable the tube driver |
| pump_clk | output | 1 | Pump square wave |
| fil_phase1 | output | 1 | Filament phase 1 |
| fil_phase2 | output | 1 | Filament phase 2 |
| blink_phase | output | 1 | Blink on/off phase |

## Verification
The bench runs a small configuration: 4-clock slots, 6 or 3 slots, and 16- or 32-clock blink half-periods. At every clock it compares all outputs against values computed from the number of clocks since the last wake or sync. A first wake with the narrow count and fast blink exercises the blanked first scan and the drive waveforms. A sync together with a change to the wide count and the slow blink shows that the scan and blink restart while the drive counters keep running. Dropping the run request part-way through a slot separates a stop at the slot's end from an immediate one. A wake through test mode with the pump and one filament disabled checks the override and the gating. A switch to the narrow count while on slot 4 checks the wrap.

// File: rtl/vfd_mux_seq.sv
module vfd_mux_seq #(
  parameter int SLOT_CLKS    = 400,
  parameter int SLOTS_WIDE   = 96,
  parameter int SLOTS_NARROW = 48,
  parameter int BLINK_SHIFT  = 21,
  parameter int PUMP_DIV     = 8,
  parameter int FIL_DIV      = 4000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_run,
  input  logic                          cfg_blink_slow,
  input  logic                          cfg_sync,
  input  logic                          cfg_wide,
  input  logic                          test_mode,
  input  logic                          pump_sq_en,
  input  logic                          fil1_en,
  input  logic                          fil2_en,
  output logic [$clog2(SLOTS_WIDE)-1:0] slot_idx,
  output logic                          slot_strobe,
  output logic                          blank,
  output logic                          pump_clk,
  output logic                          fil_phase1,
  output logic                          fil_phase2,
  output logic                          blink_phase
);
  localparam int CNT_W  = $clog2(SLOT_CLKS);
  localparam int IDX_W  = $clog2(SLOTS_WIDE);
  localparam int BLK_W  = BLINK_SHIFT + 1;
  localparam int PUMP_W = $clog2(PUMP_DIV);
  localparam int FIL_W  = $clog2(FIL_DIV);

  logic             active, wake_blank;
  logic [CNT_W-1:0] slot_cnt;
  logic [BLK_W-1:0] blink_cnt;
  logic [PUMP_W-1:0] pump_cnt;
  logic [FIL_W-1:0] fil_cnt;
  logic             pump_q, fil_q;

  wire run_req    = cfg_run | test_mode;
  wire wake       = !active && run_req;
  wire period_end = active && (slot_cnt == CNT_W'(SLOT_CLKS - 1));
  wire [IDX_W-1:0] last_slot = cfg_wide ? IDX_W'(SLOTS_WIDE - 1) : IDX_W'(SLOTS_NARROW - 1);
  wire at_last    = slot_idx >= last_slot;
  wire blink_end  = active && (cfg_blink_slow ? (blink_cnt == {BLK_W{1'b1}})
                                              : (blink_cnt >= BLK_W'((1 << BLINK_SHIFT) - 1)));
  wire pump_tick  = pump_cnt == PUMP_W'(PUMP_DIV / 2 - 1);
  wire fil_tick   = fil_cnt == FIL_W'(FIL_DIV / 2 - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      wake_blank <= 1'b0;
      slot_cnt   <= '0;
      slot_idx   <= '0;
    end else begin
      if (wake) begin
        active     <= 1'b1;
        wake_blank <= 1'b1;
        slot_cnt   <= '0;
        slot_idx   <= '0;
      end else if (active) begin
        slot_cnt <= period_end ? '0 : slot_cnt + 1'b1;
        if (period_end) begin
          slot_idx <= at_last ? '0 : slot_idx + 1'b1;
          if (at_last) wake_blank <= 1'b0;
          if (!run_req) active <= 1'b0;
        end
      end
      if (cfg_sync) begin
        slot_cnt <= '0;
        slot_idx <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blink_cnt   <= '0;
      blink_phase <= 1'b0;
    end else if (wake || cfg_sync) begin
      blink_cnt   <= '0;
      blink_phase <= 1'b0;
    end else if (blink_end) begin
      blink_cnt   <= '0;
      blink_phase <= !blink_phase;
    end else if (active) begin
      blink_cnt <= blink_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pump_cnt <= '0;
      pump_q   <= 1'b0;
      fil_cnt  <= '0;
      fil_q    <= 1'b0;
    end else if (wake) begin
      pump_cnt <= '0;
      pump_q   <= 1'b0;
      fil_cnt  <= '0;
      fil_q    <= 1'b0;
    end else if (active) begin
      pump_cnt <= pump_tick ? '0 : pump_cnt + 1'b1;
      if (pump_tick) pump_q <= !pump_q;
      fil_cnt  <= fil_tick ? '0 : fil_cnt + 1'b1;
      if (fil_tick) fil_q <= !fil_q;
    end
  end

  assign slot_strobe = period_end;
  assign blank       = !active || wake_blank;
  assign pump_clk    = active && pump_sq_en && pump_q;
  assign fil_phase1  = active && fil1_en && fil_q;
  assign fil_phase2  = active && fil2_en && !fil_q;
endmodule

// File: rtl/vfd_mux_seq_chk.sv
module vfd_mux_seq_chk #(
  parameter int SLOTS_WIDE = 96
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_run,
  input logic                          cfg_sync,
  input logic                          test_mode,
  input logic                          pump_sq_en,
  input logic                          fil1_en,
  input logic                          fil2_en,
  input logic [$clog2(SLOTS_WIDE)-1:0] slot_idx,
  input logic                          slot_strobe,
  input logic                          blank,
  input logic                          pump_clk,
  input logic                          fil_phase1,
  input logic                          fil_phase2,
  input logic                          blink_phase,
  input logic                          active
);
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) 32'(slot_idx) < SLOTS_WIDE); // R1
  AST_STROBE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_strobe && !cfg_sync) |=> (slot_idx == 0 || slot_idx == $past(slot_idx) + 1'b1)); // R1
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_strobe && !cfg_sync && active) |=> $stable(slot_idx)); // R1
  AST_RUN_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !slot_strobe) |=> active); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (blank && !slot_strobe)); // R3
  AST_PUMP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || !pump_sq_en) |-> !pump_clk); // R4
  AST_PHASE_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fil1_en && fil2_en) |-> (fil_phase1 != fil_phase2)); // R5
  AST_WAKE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && (cfg_run || test_mode)) |=> (blank && slot_idx == 0)); // R6
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sync |=> (slot_idx == 0 && !blink_phase)); // R8
endmodule

bind vfd_mux_seq vfd_mux_seq_chk #(.SLOTS_WIDE(SLOTS_WIDE)) u_chk (.*);

// File: tb/vfd_mux_seq_tb.sv
`timescale 1ns/1ps
module vfd_mux_seq_tb;
  localparam int SC = 4, NW = 6, NN = 3, SH = 4, PD = 4, FD = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_run = 0, cfg_blink_slow = 0, cfg_sync = 0, cfg_wide = 0, test_mode = 0;
  logic pump_sq_en = 0, fil1_en = 0, fil2_en = 0;
  logic [$clog2(NW)-1:0] slot_idx;
  logic slot_strobe, blank, pump_clk, fil_phase1, fil_phase2, blink_phase;
  int n_chk = 0, n_fail = 0;
  int ms, mo, mh, hslot;

  always #4 clk = ~clk;

  vfd_mux_seq #(.SLOT_CLKS(SC), .SLOTS_WIDE(NW), .SLOTS_NARROW(NN), .BLINK_SHIFT(SH),
                .PUMP_DIV(PD), .FIL_DIV(FD)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_run(string req, int s, int o, int ns, int bl, int exp_blank);
    chk({req, " slot"}, slot_idx, (s / SC) % ns);
    chk("R1 strobe", slot_strobe, (s % SC) == SC - 1);
    chk("R6 blank", blank, exp_blank);
    chk("R4 pump", pump_clk, pump_sq_en ? (o / (PD / 2)) % 2 : 0);
    chk("R5 phase1", fil_phase1, fil1_en ? (o / (FD / 2)) % 2 : 0);
    chk("R5 phase2", fil_phase2, fil2_en ? 1 - (o / (FD / 2)) % 2 : 0);
    chk("R9 blink", blink_phase, (s / bl) % 2);
  endtask

  task automatic check_halted(string req, int exp_slot);
    chk({req, " blank"}, blank, 1);
    chk({req, " strobe"}, slot_strobe, 0);
    chk({req, " slot"}, slot_idx, exp_slot);
    chk("R4 pump off", pump_clk, 0);
    chk("R5 phases off", fil_phase1 | fil_phase2, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check_halted("R11", 0);
    chk("R11 blink", blink_phase, 0);

    // R1 R4 R5 R6 R9: wake, narrow scan, fast blink
    cfg_run = 1; pump_sq_en = 1; fil1_en = 1; fil2_en = 1;
    for (int j = 1; j <= 80; j++) begin
      @(negedge clk);
      check_run("R1", j - 1, j - 1, NN, 1 << SH, (j - 1) < NN * SC);
    end

    // R8: sync with wide scan and slow blink
    cfg_sync = 1; cfg_wide = 1; cfg_blink_slow = 1;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      cfg_sync = 0;
      ms = k; mo = 80 + k;
      check_run("R8", ms, mo, NW, 2 << SH, 0);
    end

    // R2 R3: drop run request part-way through a slot
    while (ms % SC != 1) begin
      @(negedge clk);
      ms++; mo++;
      check_run("R2", ms, mo, NW, 2 << SH, 0);
    end
    cfg_run = 0;
    mh = ms + (SC - 1 - ms % SC);
    hslot = ((mh + 1) / SC) % NW;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      ms++; mo++;
      if (ms <= mh) check_run("R2", ms, mo, NW, 2 << SH, 0);
      else check_halted("R3", hslot);
    end

    // R7: test mode overrides shutdown; pump and filament 1 disabled
    test_mode = 1; pump_sq_en = 0; fil1_en = 0;
    for (int j = 1; j <= 41; j++) begin
      @(negedge clk);
      check_run("R7", j - 1, j - 1, NW, 2 << SH, (j - 1) < NW * SC);
    end

    // R10: shrink to narrow count while on slot 4
    chk("R10 start slot", slot_idx, 4);
    cfg_wide = 0;
    for (int s = 41; s <= 70; s++) begin
      @(negedge clk);
      chk("R10 slot", slot_idx, (s < 44) ? 4 : ((s - 44) / SC) % NN);
      chk("R10 strobe", slot_strobe, (s % SC) == SC - 1);
    end

    // R7 R3: leaving test mode with run low stops the scan
    test_mode = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 4) begin
        chk("R3 blank after test", blank, 1);
        chk("R3 strobe after test", slot_strobe, 0);
      end
    end
    finish_run();
  end
endmodule